// File: doc/BRIEF.md
# Round-Robin Relocation Set Finder

This block chooses a cache set that can take a block being pushed out of its home set. It holds a small number of property vectors, each with one bit per cache set. A bit is set when that set meets the property of its vector: it has a free way, its oldest block has no private copy, it has a likely-dead block with no private copy, or it has any block with no private copy. Logic outside the block keeps the bits current. It writes them one bit at a time through an update port.

A search starts from the one-hot home set. For every vector the block finds the nearest set bit strictly above the home position. If there is none, it wraps around to the lowest set bit at or below the home position. The index never leaves one-hot form: a position mask splits each vector into an upper part and a lower part, and the lowest bit of the part in use is isolated with two's-complement arithmetic. The vectors are then visited in a fixed priority order. At each level, if the home set's own bit is set, no relocation is needed. Otherwise, if the vector has any bit set, its next position is the answer. If every vector is empty, the block reports that no candidate exists.

The search runs through a state machine with four states. Idle waits for a request. Idle goes to Isolate when a request is accepted, and the position masks are applied on that edge. Isolate always goes to Select, with the one-hot next positions registered. Select always goes to Report, with the priority choice registered to the outputs. Report goes to Isolate if a new request is accepted, and to Idle otherwise. Requests are accepted only in Idle and Report. This gives a three-cycle latency and a three-cycle repeat interval.

Top module: `rsf_finder`

## Requirements
- R1: After reset, `ready` is 1 and `rsp_valid` is 0, and every property vector is cleared, so a search made right after reset reports no candidate.
- R2: When `upd_valid` is 1 at a clock edge, vector `upd_prop` at set `upd_set` takes the value `upd_bit`. An update in the same cycle as an accepted request is seen only by later searches.
- R3: For the deciding vector, the reported set is the lowest set bit strictly above the home position. If no bit is set above the home position, it is the lowest set bit at or below the home position.
- R4: Vectors are visited in the order index 0 (free way), index 1 (oldest block has no private copy), index 2 (likely-dead block has no private copy), index 3 (any block has no private copy). The first level whose vector is non-empty decides the result, and lower levels are ignored.
- R5: If the home set's bit is set in the deciding level, `rsp_no_reloc` is 1 and `rsp_set` equals the home set.
- R6: If every vector is empty, `rsp_none` is 1, `rsp_set` is all zeros and `rsp_no_reloc` is 0.
- R7: A request accepted in cycle c, meaning `req_valid` and `ready` are both 1, gives `rsp_valid` = 1 in cycle c+3, and only for that one cycle.
- R8: `ready` is 0 for the two cycles after an accepted request and is 1 again in the third. A request presented while `ready` is 0 is ignored and produces no response.
- R9: Whenever `rsp_valid` is 1 and `rsp_none` is 0, `rsp_set` has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Property bit write enable |
| upd_prop | input | PROP_W | Vector to write (0 is highest priority) |
| upd_set | input | SET_W | Set index to write, binary |
| upd_bit | input | 1 | Value written |
| req_valid | input | 1 | Search request |
| req_home | input | NUM_SETS | One-hot home set |
| ready | output | 1 | Request can be accepted this cycle |
| rsp_valid | output | 1 | Result valid, one cycle |
| rsp_set | output | NUM_SETS | One-hot chosen set |
| rsp_no_reloc | output | 1 | Home set already qualifies |
| rsp_none | output | 1 | No vector has any set marked |

## Verification
The table of patterns places a single marked set above the home, a marked set that forces a wrap from the top position, two marks on either side of the home, and a home at bit 0 and at bit 15. Together these separate a correct upper/lower split from an off-by-one mask. Other rows fill several vectors at once with different winners. These rows show whether priority follows vector order, and whether a home bit set only in a lower-priority vector wrongly triggers the no-relocation result. Directed cases cover an update that coincides with a request, a request presented while busy, a back-to-back request at the repeat interval, and the all-empty case.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_ISOLATE = 2'd1,
        S_SELECT  = 2'd2,
        S_REPORT  = 2'd3
    } rsf_state_e;
endpackage

// File: rtl/rsf_prop_store.sv
module rsf_prop_store #(
    parameter int NUM_SETS  = 16,
    parameter int NUM_PROPS = 4,
    localparam int SET_W  = $clog2(NUM_SETS),
    localparam int PROP_W = (NUM_PROPS > 1) ? $clog2(NUM_PROPS) : 1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [PROP_W-1:0]                    wr_prop,
    input  logic [SET_W-1:0]                     wr_set,
    input  logic                                 wr_bit,
    output logic [NUM_PROPS-1:0][NUM_SETS-1:0]   vec
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec <= '0;
        end else if (wr_en && (int'(wr_prop) < NUM_PROPS)) begin
            vec[wr_prop][wr_set] <= wr_bit;
        end
    end
endmodule

// File: rtl/rsf_split.sv
module rsf_split #(
    parameter int NUM_SETS = 16
) (
    input  logic [NUM_SETS-1:0] vec,
    input  logic [NUM_SETS-1:0] home,
    output logic [NUM_SETS-1:0] upper,
    output logic [NUM_SETS-1:0] lower
);
    logic [NUM_SETS-1:0] shifted;
    logic [NUM_SETS-1:0] at_or_below;

    always_comb begin
        shifted     = home << 1;
        at_or_below = shifted - NUM_SETS'(1);
        upper       = vec & ~at_or_below;
        lower       = vec & at_or_below;
    end
endmodule

// File: rtl/rsf_isolate.sv
module rsf_isolate #(
    parameter int NUM_SETS = 16
) (
    input  logic [NUM_SETS-1:0] upper,
    input  logic [NUM_SETS-1:0] lower,
    output logic [NUM_SETS-1:0] next_pos
);
    logic [NUM_SETS-1:0] part;

    always_comb begin
        part     = (|upper) ? upper : lower;
        next_pos = part & (~part + NUM_SETS'(1));
    end
endmodule

// File: rtl/rsf_select.sv
module rsf_select #(
    parameter int NUM_SETS  = 16,
    parameter int NUM_PROPS = 4
) (
    input  logic [NUM_PROPS-1:0][NUM_SETS-1:0] next_pos,
    input  logic [NUM_PROPS-1:0]               home_hit,
    input  logic [NUM_PROPS-1:0]               non_empty,
    input  logic [NUM_SETS-1:0]                home,
    output logic [NUM_SETS-1:0]                pick,
    output logic                               stay,
    output logic                               empty
);
    logic decided;

    always_comb begin
        pick    = '0;
        stay    = 1'b0;
        empty   = 1'b1;
        decided = 1'b0;
        for (int p = 0; p < NUM_PROPS; p++) begin
            if (!decided) begin
                if (home_hit[p]) begin
                    pick    = home;
                    stay    = 1'b1;
                    empty   = 1'b0;
                    decided = 1'b1;
                end else if (non_empty[p]) begin
                    pick    = next_pos[p];
                    empty   = 1'b0;
                    decided = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rsf_finder.sv
module rsf_finder #(
    parameter int NUM_SETS  = 16,
    parameter int NUM_PROPS = 4,
    localparam int SET_W  = $clog2(NUM_SETS),
    localparam int PROP_W = (NUM_PROPS > 1) ? $clog2(NUM_PROPS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_valid,
    input  logic [PROP_W-1:0]   upd_prop,
    input  logic [SET_W-1:0]    upd_set,
    input  logic                upd_bit,
    input  logic                req_valid,
    input  logic [NUM_SETS-1:0] req_home,
    output logic                ready,
    output logic                rsp_valid,
    output logic [NUM_SETS-1:0] rsp_set,
    output logic                rsp_no_reloc,
    output logic                rsp_none
);
    import rsf_pkg::*;

    rsf_state_e state_q, state_d;
    logic       accept;

    logic [NUM_PROPS-1:0][NUM_SETS-1:0] vec;
    logic [NUM_PROPS-1:0][NUM_SETS-1:0] upper_d, lower_d;
    logic [NUM_PROPS-1:0][NUM_SETS-1:0] upper_q, lower_q;
    logic [NUM_PROPS-1:0][NUM_SETS-1:0] next_d, next_q;
    logic [NUM_PROPS-1:0]               hit_d, hit_q, any_d, any_q;
    logic [NUM_SETS-1:0]                home_q;
    logic [NUM_SETS-1:0]                pick;
    logic                               stay, empty;

    rsf_prop_store #(.NUM_SETS(NUM_SETS), .NUM_PROPS(NUM_PROPS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (upd_valid),
        .wr_prop (upd_prop),
        .wr_set  (upd_set),
        .wr_bit  (upd_bit),
        .vec     (vec)
    );

    for (genvar p = 0; p < NUM_PROPS; p++) begin : g_prop
        rsf_split #(.NUM_SETS(NUM_SETS)) u_split (
            .vec   (vec[p]),
            .home  (req_home),
            .upper (upper_d[p]),
            .lower (lower_d[p])
        );
        rsf_isolate #(.NUM_SETS(NUM_SETS)) u_iso (
            .upper    (upper_q[p]),
            .lower    (lower_q[p]),
            .next_pos (next_d[p])
        );
        assign hit_d[p] = |(lower_q[p] & home_q);
        assign any_d[p] = |(upper_q[p] | lower_q[p]);
    end

    rsf_select #(.NUM_SETS(NUM_SETS), .NUM_PROPS(NUM_PROPS)) u_sel (
        .next_pos  (next_q),
        .home_hit  (hit_q),
        .non_empty (any_q),
        .home      (home_q),
        .pick      (pick),
        .stay      (stay),
        .empty     (empty)
    );

    assign ready  = (state_q == S_IDLE) || (state_q == S_REPORT);
    assign accept = ready && req_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (accept) state_d = S_ISOLATE;
            S_ISOLATE: state_d = S_SELECT;
            S_SELECT:  state_d = S_REPORT;
            S_REPORT:  state_d = accept ? S_ISOLATE : S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            lower_q <= '0;
            home_q  <= '0;
        end else if (accept) begin
            upper_q <= upper_d;
            lower_q <= lower_d;
            home_q  <= req_home;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_q <= '0;
            hit_q  <= '0;
            any_q  <= '0;
        end else if (state_q == S_ISOLATE) begin
            next_q <= next_d;
            hit_q  <= hit_d;
            any_q  <= any_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_set      <= '0;
            rsp_no_reloc <= 1'b0;
            rsp_none     <= 1'b0;
        end else begin
            rsp_valid <= (state_q == S_SELECT);
            if (state_q == S_SELECT) begin
                rsp_set      <= pick;
                rsp_no_reloc <= stay;
                rsp_none     <= empty;
            end
        end
    end
endmodule

// File: rtl/rsf_finder_checker.sv
module rsf_finder_checker #(
    parameter int NUM_SETS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [NUM_SETS-1:0] req_home,
    input logic                ready,
    input logic                rsp_valid,
    input logic [NUM_SETS-1:0] rsp_set,
    input logic                rsp_no_reloc,
    input logic                rsp_none
);
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |-> ##3 rsp_valid);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r8_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !ready ##1 !ready ##1 ready);

    a_r9_onehot_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_none) |-> ($countones(rsp_set) == 1));

    a_r6_empty_result: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_none) |-> (rsp_set == '0 && !rsp_no_reloc));

    a_r5_home_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_no_reloc) |-> (rsp_set == $past(req_home, 3)));
endmodule

bind rsf_finder rsf_finder_checker #(.NUM_SETS(NUM_SETS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_home     (req_home),
    .ready        (ready),
    .rsp_valid    (rsp_valid),
    .rsp_set      (rsp_set),
    .rsp_no_reloc (rsp_no_reloc),
    .rsp_none     (rsp_none)
);

// File: tb/tb_rsf_finder.sv
module tb_rsf_finder;
    localparam int N = 16;
    localparam int P = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         upd_valid = 1'b0;
    logic [1:0]   upd_prop = '0;
    logic [3:0]   upd_set = '0;
    logic         upd_bit = 1'b0;
    logic         req_valid = 1'b0;
    logic [N-1:0] req_home = '0;
    logic         ready, rsp_valid, rsp_no_reloc, rsp_none;
    logic [N-1:0] rsp_set;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rsf_finder #(.NUM_SETS(N), .NUM_PROPS(P)) dut (
        .clk(clk), .rst_n(rst_n),
        .upd_valid(upd_valid), .upd_prop(upd_prop), .upd_set(upd_set), .upd_bit(upd_bit),
        .req_valid(req_valid), .req_home(req_home),
        .ready(ready), .rsp_valid(rsp_valid), .rsp_set(rsp_set),
        .rsp_no_reloc(rsp_no_reloc), .rsp_none(rsp_none)
    );

    typedef struct packed {
        logic [N-1:0] v3, v2, v1, v0;
        logic [3:0]   home;
        logic [3:0]   exp_idx;
        logic         exp_nr;
        logic         exp_none;
    } row_t;

    localparam int ROWS = 13;
    localparam row_t TABLE [ROWS] = '{
        '{16'h0120, 16'h0000, 16'h0000, 16'h0000, 4'd3,  4'd5,  1'b0, 1'b0}, // R3 next above
        '{16'h0120, 16'h0000, 16'h0000, 16'h0000, 4'd6,  4'd8,  1'b0, 1'b0}, // R3
        '{16'h0120, 16'h0000, 16'h0000, 16'h0000, 4'd9,  4'd5,  1'b0, 1'b0}, // R3 wrap
        '{16'h8001, 16'h0000, 16'h0000, 16'h0000, 4'd14, 4'd15, 1'b0, 1'b0}, // R3 top bit
        '{16'h0001, 16'h0000, 16'h0000, 16'h0000, 4'd15, 4'd0,  1'b0, 1'b0}, // R3 wrap from top
        '{16'h0002, 16'h0000, 16'h0000, 16'h0400, 4'd4,  4'd10, 1'b0, 1'b0}, // R4 level 0 wins
        '{16'hFFFF, 16'h0004, 16'h0800, 16'h0000, 4'd4,  4'd11, 1'b0, 1'b0}, // R4 level 1 wins
        '{16'h0100, 16'h0044, 16'h0000, 16'h0000, 4'd7,  4'd2,  1'b0, 1'b0}, // R4 level 2 wraps
        '{16'h0000, 16'h0000, 16'h0010, 16'h0000, 4'd4,  4'd4,  1'b1, 1'b0}, // R5 level 1 home
        '{16'h0081, 16'h0000, 16'h0000, 16'h0000, 4'd7,  4'd7,  1'b1, 1'b0}, // R5 level 3 home
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'd2,  4'd0,  1'b0, 1'b1}, // R6 all empty
        '{16'h0000, 16'h0000, 16'h0000, 16'h2000, 4'd13, 4'd13, 1'b1, 1'b0}, // R5 level 0 home
        '{16'h0000, 16'h8000, 16'h0000, 16'h0000, 4'd0,  4'd15, 1'b0, 1'b0}  // R3 home at bit 0
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_bit(input int p, input int s, input logic b);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_prop  = 2'(p);
        upd_set   = 4'(s);
        upd_bit   = b;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic load(input logic [N-1:0] v0, v1, v2, v3);
        logic [N-1:0] vs [P];
        vs[0] = v0; vs[1] = v1; vs[2] = v2; vs[3] = v3;
        for (int p = 0; p < P; p++) begin
            for (int s = 0; s < N; s++) begin
                @(negedge clk);
                upd_valid = 1'b1;
                upd_prop  = 2'(p);
                upd_set   = 4'(s);
                upd_bit   = vs[p][s];
            end
        end
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    // Present a request at a negedge while ready, return sampled at the negedge after rsp_valid rises
    task automatic search(input int h, output logic [N-1:0] set_o,
                          output logic nr_o, output logic none_o, output logic vld_o);
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1;
        req_home  = N'(1) << h;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        vld_o  = rsp_valid;
        set_o  = rsp_set;
        nr_o   = rsp_no_reloc;
        none_o = rsp_none;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog R7: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] s;
        logic nr, no, v;
        int pulses;

        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 ready", 32'(ready), 32'd1);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        search(0, s, nr, no, v);
        chk("R1 empty after reset", 32'({v, no}), 32'b11);

        // Table walk
        for (int i = 0; i < ROWS; i++) begin
            logic [N-1:0] exp_set;
            load(TABLE[i].v0, TABLE[i].v1, TABLE[i].v2, TABLE[i].v3);
            search(int'(TABLE[i].home), s, nr, no, v);
            exp_set = TABLE[i].exp_none ? '0 : (N'(1) << TABLE[i].exp_idx);
            chk($sformatf("R3/R4/R5/R6 row %0d valid", i), 32'(v), 32'd1);
            chk($sformatf("R3/R4/R5/R6 row %0d set", i), 32'(s), 32'(exp_set));
            chk($sformatf("R5 row %0d no_reloc", i), 32'(nr), 32'(TABLE[i].exp_nr));
            chk($sformatf("R6 row %0d none", i), 32'(no), 32'(TABLE[i].exp_none));
        end

        // R2: update coinciding with request is not seen by that request
        load('0, '0, '0, '0);
        @(negedge clk);
        req_valid = 1'b1; req_home = N'(1) << 3;
        upd_valid = 1'b1; upd_prop = 2'd3; upd_set = 4'd9; upd_bit = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; upd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R2 same-cycle update unseen", 32'({rsp_valid, rsp_none}), 32'b11);
        search(3, s, nr, no, v);
        chk("R2 update seen later", 32'(s), 32'(N'(1) << 9));
        write_bit(3, 9, 1'b0);
        search(3, s, nr, no, v);
        chk("R2 clearing write", 32'(no), 32'd1);
        write_bit(3, 9, 1'b1);

        // R7/R8: latency, busy window, ignored request, back-to-back
        @(negedge clk);
        req_valid = 1'b1; req_home = N'(1) << 3;
        @(negedge clk);                              // cycle c+1
        chk("R8 busy c+1", 32'(ready), 32'd0);
        chk("R7 no early rsp c+1", 32'(rsp_valid), 32'd0);
        req_home = N'(1) << 9;                       // should be ignored
        @(negedge clk);                              // cycle c+2
        chk("R8 busy c+2", 32'(ready), 32'd0);
        chk("R7 no early rsp c+2", 32'(rsp_valid), 32'd0);
        req_valid = 1'b0;
        @(negedge clk);                              // cycle c+3
        chk("R7 rsp at c+3", 32'(rsp_valid), 32'd1);
        chk("R7 rsp set", 32'(rsp_set), 32'(N'(1) << 9));
        chk("R7 rsp not home", 32'(rsp_no_reloc), 32'd0);
        chk("R8 ready at c+3", 32'(ready), 32'd1);
        req_valid = 1'b1; req_home = N'(1) << 9;     // back-to-back accept
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 single pulse", 32'(rsp_valid), 32'd0);
        @(negedge clk);
        chk("R7 gap", 32'(rsp_valid), 32'd0);
        @(negedge clk);
        chk("R8 back-to-back rsp", 32'({rsp_valid, rsp_no_reloc}), 32'b11);
        pulses = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (rsp_valid) pulses++;
        end
        chk("R8 ignored request gave no rsp", 32'(pulses), 32'd0);

        // R9: one-hot pick with many bits set
        load(16'hF0F0, '0, '0, '0);
        search(2, s, nr, no, v);
        chk("R9 onehot count", 32'($countones(s)), 32'd1);
        chk("R9 value", 32'(s), 32'(N'(1) << 4));

        // R1: reset mid-run clears vectors
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 ready in reset", 32'(ready), 32'd1);
        rst_n = 1'b1;
        search(2, s, nr, no, v);
        chk("R1 vectors cleared", 32'(no), 32'd1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule